// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer and Access Gate

This block sits in front of a crypto engine and decides when that engine may be used. Out of reset it runs three external test agents one after another: the algorithm known-answer test, then the random generator known-answer test, then the integrity check of the loaded binary. Each agent is launched by a one-cycle start strobe and answers with a done pulse that carries a pass/fail verdict. The whole chain has exactly two outcomes. Either every stage passes and the engine opens, or one stage fails and the block locks into a fatal state that only a reset clears.

An 8-bit status code shows progress at all times. After reset it reads 0xFF. It then steps to 1, 2 and 3 as the stages pass. A build parameter selects operation outside the certified mode, and in that build the code always reads 0. Client requests use a request/grant handshake. The client raises `req_valid` together with a source tag, and the block answers in the same cycle on `req_grant`. A request that is not granted is back-pressured: the client holds `req_valid` and its tag until a grant arrives, and no request is queued inside the block. While the integrity stage is running, only the integrity checker's own source tag may pass, because that check needs the engine to hash the binary.

Top module: `selftest_gate`

## Requirements
- R1: While reset is held, and until the first pass, `status` reads 0xFF, `fatal` is 0 and no request is granted. The first start strobe (bit 0, the algorithm test) is visible in the cycle after the first clock edge with reset released.
- R2: `st_start` bits are bit 0 for the algorithm known-answer test, bit 1 for the random generator test and bit 2 for the integrity check. The bits are at most one-hot and each strobe lasts exactly one cycle. The strobe of the next stage appears two cycles after the edge on which the previous stage's pass was sampled.
- R3: The edge that samples done with pass high for stage 0, 1 or 2 sets `status` to 1, 2 or 3, and the new value is visible in the following cycle. Once `status` is 3 it stays 3 until reset.
- R4: Done is accepted only from the stage currently awaiting its result. A done pulse from any other stage bit, and a pass level without done, leave `status`, `fatal` and the strobes unchanged.
- R5: Before the integrity stage starts, every request is refused. From the integrity stage's launch until its done, a request is granted only when `req_src` equals `INTEG_SRC` (default 15).
- R6: After all three stages pass, every request with `req_valid` high is granted in the same cycle. `req_grant` is never high while `req_valid` is low.
- R7: A done with pass low sets `fatal` in the next cycle. `fatal` then stays high, no further strobe is issued, `status` keeps its last value and no request is granted, whatever the agents do afterwards.
- R8: Reset returns the block to the R1 state from any state, including the fatal and the fully passed states.
- R9: With `NON_FIPS` = 1, `status` reads 0 at all times. Sequencing, `fatal` and `req_grant` behave exactly as in the default build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_start | output | 3 | One-cycle launch strobes, one bit per stage |
| st_done | input | 3 | Stage done pulses, one bit per stage |
| st_pass | input | 3 | Stage verdicts, sampled only together with done |
| req_valid | input | 1 | Client request present |
| req_src | input | SRC_W (4) | Source tag of the request |
| req_grant | output | 1 | Request granted in this cycle |
| status | output | 8 | Progress code: 0xFF, 1, 2, 3, or 0 in the non-certified build |
| fatal | output | 1 | Sticky self-test failure flag |

## Verification
The bench builds two copies side by side from the same agent and client stimulus. One uses the default parameters (certified build, integrity tag 15, 4-bit tag). The other sets `NON_FIPS` = 1. Comparing the two cycle by cycle shows that the reporting mode changes only the status code and never the gating. A random tag generator biased toward tag 15 reaches the narrow integrity-stage window, where one tag must pass and its neighbours must not. Directed runs place a failure at each stage so that every fatal lock-up point is covered.

// File: rtl/stsg_pkg.sv
package stsg_pkg;
  localparam int STAGES = 3;
  localparam int IDX_W  = $clog2(STAGES);
  localparam int STS_W  = 8;

  localparam logic [STS_W-1:0] STS_BOOT   = 8'hFF;
  localparam logic [STS_W-1:0] STS_NOCERT = 8'h00;

  typedef enum logic [1:0] {
    PH_LAUNCH,
    PH_WAIT,
    PH_DONE,
    PH_HALT
  } phase_e;

  function automatic logic [STS_W-1:0] stage_code(input logic [IDX_W-1:0] idx);
    return STS_W'(idx) + STS_W'(1);
  endfunction
endpackage

// File: rtl/stsg_sequencer.sv
module stsg_sequencer
  import stsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] done_i,
  input  logic [STAGES-1:0] pass_i,
  output logic [STAGES-1:0] start_o,
  output logic              step_o,
  output logic [IDX_W-1:0]  step_idx_o,
  output logic              fail_o,
  output logic              all_ok_o,
  output logic              integ_o
);
  phase_e             phase_q;
  logic [IDX_W-1:0]   cur_q;
  logic [STAGES-1:0]  strobe_q;
  logic [STAGES-1:0]  launch_vec;
  logic               done_sel;
  logic               pass_sel;
  logic               accept;
  logic               last;

  // one select line per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_sel
    assign launch_vec[g] = (cur_q == IDX_W'(g));
  end

  // route the current stage's handshake; other stage bits are ignored
  always_comb begin
    done_sel = 1'b0;
    pass_sel = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (launch_vec[i]) begin
        done_sel = done_i[i];
        pass_sel = pass_i[i];
      end
    end
  end

  assign accept     = (phase_q == PH_WAIT) && done_sel;
  assign last       = (cur_q == IDX_W'(STAGES - 1));
  assign step_o     = accept && pass_sel;
  assign fail_o     = accept && !pass_sel;
  assign step_idx_o = cur_q;
  assign start_o    = strobe_q;
  assign all_ok_o   = (phase_q == PH_DONE);
  assign integ_o    = last && ((phase_q == PH_LAUNCH) || (phase_q == PH_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_LAUNCH;
      cur_q    <= '0;
      strobe_q <= '0;
    end else begin
      strobe_q <= '0;
      unique case (phase_q)
        PH_LAUNCH: begin
          strobe_q <= launch_vec;
          phase_q  <= PH_WAIT;
        end
        PH_WAIT: begin
          if (fail_o) begin
            phase_q <= PH_HALT;
          end else if (step_o) begin
            if (last) begin
              phase_q <= PH_DONE;
            end else begin
              cur_q   <= cur_q + IDX_W'(1);
              phase_q <= PH_LAUNCH;
            end
          end
        end
        PH_DONE: phase_q <= PH_DONE;
        PH_HALT: phase_q <= PH_HALT;
        default: phase_q <= PH_HALT;
      endcase
    end
  end
endmodule

// File: rtl/stsg_status.sv
module stsg_status
  import stsg_pkg::*;
#(
  parameter bit NON_FIPS = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [IDX_W-1:0] step_idx_i,
  input  logic             fail_i,
  output logic [STS_W-1:0] status_o,
  output logic             fatal_o
);
  logic fatal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fatal_q <= 1'b0;
    else if (fail_i) fatal_q <= 1'b1;
  end
  assign fatal_o = fatal_q;

  if (NON_FIPS) begin : g_nocert
    assign status_o = STS_NOCERT;
  end else begin : g_cert
    logic [STS_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= STS_BOOT;
      else if (step_i && !fatal_q) code_q <= stage_code(step_idx_i);
    end
    assign status_o = code_q;
  end
endmodule

// File: rtl/stsg_gate.sv
module stsg_gate #(
  parameter int SRC_W     = 4,
  parameter int INTEG_SRC = 15
) (
  input  logic             req_valid_i,
  input  logic [SRC_W-1:0] req_src_i,
  input  logic             all_ok_i,
  input  logic             integ_i,
  input  logic             fatal_i,
  output logic             req_grant_o
);
  localparam logic [SRC_W-1:0] TAG = SRC_W'(INTEG_SRC);

  logic open_all;
  logic open_integ;

  assign open_all    = all_ok_i && !fatal_i;
  assign open_integ  = integ_i && !fatal_i && (req_src_i == TAG);
  assign req_grant_o = req_valid_i && (open_all || open_integ);
endmodule

// File: rtl/selftest_gate.sv
module selftest_gate
  import stsg_pkg::*;
#(
  parameter bit NON_FIPS  = 1'b0,
  parameter int SRC_W     = 4,
  parameter int INTEG_SRC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] st_start,
  input  logic [STAGES-1:0] st_done,
  input  logic [STAGES-1:0] st_pass,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  output logic              req_grant,
  output logic [STS_W-1:0]  status,
  output logic              fatal
);
  logic             step;
  logic [IDX_W-1:0] step_idx;
  logic             fail;
  logic             all_ok;
  logic             integ;

  stsg_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (st_done),
    .pass_i     (st_pass),
    .start_o    (st_start),
    .step_o     (step),
    .step_idx_o (step_idx),
    .fail_o     (fail),
    .all_ok_o   (all_ok),
    .integ_o    (integ)
  );

  stsg_status #(.NON_FIPS(NON_FIPS)) u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .step_idx_i (step_idx),
    .fail_i     (fail),
    .status_o   (status),
    .fatal_o    (fatal)
  );

  stsg_gate #(.SRC_W(SRC_W), .INTEG_SRC(INTEG_SRC)) u_gate (
    .req_valid_i (req_valid),
    .req_src_i   (req_src),
    .all_ok_i    (all_ok),
    .integ_i     (integ),
    .fatal_i     (fatal),
    .req_grant_o (req_grant)
  );
endmodule

// File: rtl/stsg_checker.sv
module stsg_checker #(
  parameter bit NON_FIPS = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st_start,
  input logic [2:0] st_done,
  input logic       req_valid,
  input logic       req_grant,
  input logic [7:0] status,
  input logic       fatal
);
  assert_start_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_start));

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_start != 3'b000) |=> (st_start == 3'b000));

  assert_status_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> $past(st_done != 3'b000));

  assert_status_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!NON_FIPS && status == 8'd3) |=> (status == 8'd3));

  assert_boot_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!NON_FIPS && status == 8'hFF) |-> !req_grant);

  assert_grant_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> req_valid);

  assert_fatal_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);

  assert_fatal_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> (!req_grant && st_start == 3'b000));

  assert_fatal_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fatal) |-> $stable(status));

  assert_nocert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    NON_FIPS |-> (status == 8'h00));
endmodule

bind selftest_gate stsg_checker #(.NON_FIPS(NON_FIPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_start  (st_start),
  .st_done   (st_done),
  .req_valid (req_valid),
  .req_grant (req_grant),
  .status    (status),
  .fatal     (fatal)
);

// File: tb/sim_selftest_gate.sv
`timescale 1ns/1ps
module sim_selftest_gate;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [2:0] done, pass;
  logic       vld;
  logic [3:0] src;
  wire  [2:0] start0, start1;
  wire        gnt0, gnt1, fat0, fat1;
  wire  [7:0] sts0, sts1;

  selftest_gate #(.NON_FIPS(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .st_start(start0), .st_done(done), .st_pass(pass),
    .req_valid(vld), .req_src(src), .req_grant(gnt0), .status(sts0), .fatal(fat0));

  selftest_gate #(.NON_FIPS(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .st_start(start1), .st_done(done), .st_pass(pass),
    .req_valid(vld), .req_src(src), .req_grant(gnt1), .status(sts1), .fatal(fat1));

  int total = 0;
  int bad   = 0;
  int passed_n;
  bit failed_f;

  function automatic logic [7:0] exp_status(int n);
    return (n == 0) ? 8'hFF : 8'(n);
  endfunction

  function automatic bit exp_grant(bit v, logic [3:0] s, int n, bit f);
    if (!v || f) return 1'b0;
    if (n == 3) return 1'b1;
    if (n == 2) return (s == 4'hF);
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // random client traffic plus ignored agent noise, one cycle per loop
  task automatic probe(string tag, int n, int excl);
    for (int k = 0; k < n; k++) begin
      vld = 1'($urandom_range(0, 1));
      src = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom_range(0, 15));
      pass = 3'($urandom_range(0, 7));
      if (excl >= 0) done = 3'b001 << ((excl + 1 + $urandom_range(0, 1)) % 3);
      else done = 3'($urandom_range(0, 7));
      #1;
      chk({tag, " grant"}, 32'(gnt0), 32'(exp_grant(vld, src, passed_n, failed_f)));
      chk("R9 grant match", 32'(gnt1), 32'(gnt0));
      @(negedge clk);
      chk("R4 status held", 32'(sts0), 32'(exp_status(passed_n)));
      chk("R7 fatal level", 32'(fat0), 32'(failed_f));
      chk("R2 no strobe", 32'(start0), 32'd0);
      chk("R9 status zero", 32'(sts1), 32'd0);
      chk("R9 fatal match", 32'(fat1), 32'(fat0));
    end
    vld = 1'b0; done = 3'b000; pass = 3'b000;
  endtask

  task automatic do_reset(string tag);
    rst_n = 1'b0; done = '0; pass = '0; vld = 1'b0; src = '0;
    repeat (3) @(negedge clk);
    chk({tag, " R1 status"}, 32'(sts0), 32'hFF);
    chk({tag, " R1 fatal"}, 32'(fat0), 32'd0);
    chk({tag, " R1 strobe"}, 32'(start0), 32'd0);
    chk({tag, " R9 status"}, 32'(sts1), 32'd0);
    rst_n = 1'b1;
    passed_n = 0; failed_f = 1'b0;
    @(negedge clk);
    chk({tag, " R1 first strobe"}, 32'(start0), 32'd1);
    chk("R9 strobe match", 32'(start1), 32'(start0));
  endtask

  // precondition: strobe of stage idx is visible in this cycle
  task automatic run_stage(int idx, bit ok, int gap);
    chk("R2 strobe order", 32'(start0), 32'(3'b001 << idx));
    vld = 1'b1; src = 4'hF; #1;
    chk("R5 window grant", 32'(gnt0), 32'(idx == 2));
    vld = 1'b0;
    probe((idx == 2) ? "R5" : "R4", gap, idx);
    done = 3'b001 << idx;
    pass = 3'($urandom_range(0, 7));
    pass[idx] = ok;
    @(negedge clk);
    done = '0; pass = '0;
    if (ok) begin
      passed_n++;
      chk("R3 status step", 32'(sts0), 32'(exp_status(passed_n)));
      chk("R2 gap cycle", 32'(start0), 32'd0);
      chk("R9 status zero", 32'(sts1), 32'd0);
      if (passed_n < 3) @(negedge clk);
    end else begin
      failed_f = 1'b1;
      chk("R7 fatal set", 32'(fat0), 32'd1);
      chk("R7 status kept", 32'(sts0), 32'(exp_status(passed_n)));
      chk("R9 fatal match", 32'(fat1), 32'd1);
      probe("R7", 12, -1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // full pass
    do_reset("boot");
    run_stage(0, 1'b1, 3);
    run_stage(1, 1'b1, 0);
    run_stage(2, 1'b1, 6);
    probe("R6", 30, -1);
    vld = 1'b0; #1;
    chk("R6 no valid no grant", 32'(gnt0), 32'd0);
    // reset from opened state
    do_reset("R8 open");
    probe("R5 boot", 1, 0);
    @(negedge clk);
    // failure in random generator stage, then recovery
    do_reset("R8 again");
    run_stage(0, 1'b1, 2);
    run_stage(1, 1'b0, 1);
    do_reset("R8 fatal");
    run_stage(0, 1'b0, 0);
    do_reset("R8 fatal0");
    run_stage(0, 1'b1, 1);
    run_stage(1, 1'b1, 1);
    run_stage(2, 1'b0, 3);
    // random runs
    for (int r = 0; r < 8; r++) begin
      int fail_at;
      fail_at = $urandom_range(0, 3);
      do_reset("rand");
      for (int s = 0; s < 3; s++) begin
        run_stage(s, s != fail_at, $urandom_range(0, 4));
        if (s == fail_at) break;
      end
      if (fail_at == 3) probe("R6", 10, -1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule